// File: doc/BRIEF.md
# Critical Path Dispatch Rate Estimator

This block is the older-instruction half of an interval-style core timing model. Each committed instruction is handed in as a record: two source register ids, an optional destination register id, an execution latency, a memory address and load/store flags. The block stamps the instruction with its issue time. That time is the latest time at which any of its inputs became ready, plus the instruction's own latency. Register inputs come from a table indexed directly by register id, which holds the stamp of the last writer of each register. For loads, the youngest earlier store to the same address is found in a small store buffer, which is scanned a few lanes per cycle.

Every stamp also enters a bounded window of recent stamps. The spread between the newest stamp and the oldest stamp in that window is the critical path length. Little's law then turns the window occupancy and that length into a dispatch rate, capped at the machine width. The division is done by a shift-subtract divider, so every record takes the same fixed number of cycles. A control FSM steps through the states IDLE, SCAN, CALC and DIV:

- IDLE to SCAN when a record is accepted.
- SCAN to CALC after the last store-buffer chunk.
- CALC to DIV unconditionally.
- DIV to IDLE after the last divider step.

Top module: `cpath_rate_est`

## Requirements
- R1: After reset, `ready` is 1, `rate_valid` is 0, `rate` and `issue_stamp` are 0, and every register time and the store buffer and window are empty. An instruction with no dependencies therefore gets a stamp equal to its latency.
- R2: The stamp is max(time of `in_src_a`, time of `in_src_b`, load match time) + `in_lat`. It appears on `issue_stamp` when `rate_valid` is 1.
- R3: When `in_dst_en` is 1, the register time of `in_dst` becomes the new stamp. When `in_dst_en` is 0, no register time changes.
- R4: A record with `in_is_load`=1 also uses the stamp of the youngest earlier store (`in_is_store`=1) whose address equals `in_addr`. A load with no match, or a record that is not a load, uses register times only.
- R5: The store buffer keeps the 32 most recent stores. A store followed by 31 other stores still matches; after 32 other stores it no longer matches.
- R6: The window keeps the 128 most recent stamps, including the current one. Its occupancy n is min(records so far, 128), and the oldest stamp is the one entered n-1 records earlier.
- R7: The critical path length is newest stamp minus oldest stamp when that difference is positive. Otherwise it is 1.
- R8: `rate` = min(4, floor(n / critical path length)).
- R9: `rate_valid` pulses for exactly one cycle, 17 clock edges after the edge that accepted the record (`in_valid` and `ready` both 1). `ready` is 0 from the edge after acceptance until that pulse.
- R10: `in_valid` while `ready` is 0 is ignored. Such a record changes no register time and no store buffer entry, and it does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record offered |
| in_src_a | input | 4 | First source register id |
| in_src_b | input | 4 | Second source register id |
| in_dst | input | 4 | Destination register id |
| in_dst_en | input | 1 | Destination is written |
| in_lat | input | 4 | Execution latency |
| in_addr | input | 16 | Memory address |
| in_is_load | input | 1 | Record is a load |
| in_is_store | input | 1 | Record is a store |
| ready | output | 1 | Idle, a record may be accepted |
| rate_valid | output | 1 | One-cycle result strobe |
| rate | output | 3 | Dispatch rate |
| issue_stamp | output | 16 | Stamp of the last record |

## Verification
The bench goes after the store buffer edge. It shows that a store 31 stores back still forwards and one 32 stores back does not. A design with an off-by-one depth or the wrong scan order would forward a stale or an older store. It drives stamps that fall below the oldest window entry, where a design without the clamp to 1 would divide by a wrapped difference and give a rate of 0. It runs past 128 records, so a window that fails to evict would report too large a spread. It also pulses `in_valid` mid-operation, which a design that recaptures inputs while busy would fold into its register table.

// File: rtl/cpre_pkg.sv
package cpre_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_CALC = 2'd2,
        S_DIV  = 2'd3
    } cpre_state_t;
endpackage

// File: rtl/cpre_regmap.sv
module cpre_regmap #(
    parameter int REGS = 16,
    parameter int TS_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(REGS)-1:0]  rd_a,
    input  logic [$clog2(REGS)-1:0]  rd_b,
    output logic [TS_W-1:0]          rd_a_ts,
    output logic [TS_W-1:0]          rd_b_ts,
    input  logic                     wr_en,
    input  logic [$clog2(REGS)-1:0]  wr_id,
    input  logic [TS_W-1:0]          wr_ts
);
    logic [TS_W-1:0] tbl [REGS];

    assign rd_a_ts = tbl[rd_a];
    assign rd_b_ts = tbl[rd_b];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_id] <= wr_ts;
        end
    end
endmodule

// File: rtl/cpre_storebuf.sv
module cpre_storebuf #(
    parameter int DEPTH  = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 16,
    parameter int TS_W   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [ADDR_W-1:0]                push_addr,
    input  logic [TS_W-1:0]                  push_ts,
    input  logic [$clog2(DEPTH/LANES)-1:0]   chunk,
    input  logic [ADDR_W-1:0]                key,
    output logic                             hit,
    output logic [TS_W-1:0]                  hit_ts
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [TS_W-1:0]   ts_q   [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [IDX_W-1:0]  wp;
    logic [LANES-1:0]  lane_hit;
    logic [TS_W-1:0]   lane_ts [LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            wp      <= '0;
        end else if (push) begin
            valid_q[wp] <= 1'b1;
            wp          <= wp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wp] <= push_addr;
            ts_q[wp]   <= push_ts;
        end
    end

    // Chunks walk from the oldest slot (wp) towards the youngest.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx         = wp + IDX_W'(chunk) * IDX_W'(LANES) + IDX_W'(l);
        assign lane_hit[l] = valid_q[idx] && (addr_q[idx] == key);
        assign lane_ts[l]  = ts_q[idx];
    end

    // Higher lane is younger within the chunk.
    always_comb begin
        hit    = 1'b0;
        hit_ts = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_hit[l]) begin
                hit    = 1'b1;
                hit_ts = lane_ts[l];
            end
        end
    end
endmodule

// File: rtl/cpre_window.sv
module cpre_window #(
    parameter int WIN  = 128,
    parameter int TS_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [TS_W-1:0]            push_ts,
    output logic [$clog2(WIN+1)-1:0]   occ_next,
    output logic [TS_W-1:0]            oldest_next
);
    localparam int IDX_W = $clog2(WIN);
    localparam int CNT_W = $clog2(WIN + 1);

    logic [TS_W-1:0]  buf_q [WIN];
    logic [IDX_W-1:0] wp;
    logic [IDX_W-1:0] wp_p1;
    logic [CNT_W-1:0] cnt;
    logic             full;

    assign full  = (cnt == CNT_W'(WIN));
    assign wp_p1 = wp + 1'b1;

    // Occupancy and oldest stamp as they stand after a push this cycle.
    always_comb begin
        occ_next = full ? CNT_W'(WIN) : cnt + 1'b1;
        if (cnt == '0)  oldest_next = push_ts;
        else if (full)  oldest_next = buf_q[wp_p1];
        else            oldest_next = buf_q[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            cnt <= '0;
        end else if (push) begin
            wp <= wp_p1;
            if (!full) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) buf_q[wp] <= push_ts;
    end
endmodule

// File: rtl/cpath_rate_est.sv
module cpath_rate_est
    import cpre_pkg::*;
#(
    parameter int REGS     = 16,
    parameter int TS_W     = 16,
    parameter int LAT_W    = 4,
    parameter int ADDR_W   = 16,
    parameter int SB_DEPTH = 32,
    parameter int SB_LANES = 4,
    parameter int WIN      = 128,
    parameter int WIDTH    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [$clog2(REGS)-1:0]        in_src_a,
    input  logic [$clog2(REGS)-1:0]        in_src_b,
    input  logic [$clog2(REGS)-1:0]        in_dst,
    input  logic                           in_dst_en,
    input  logic [LAT_W-1:0]               in_lat,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic                           in_is_load,
    input  logic                           in_is_store,
    output logic                           ready,
    output logic                           rate_valid,
    output logic [$clog2(WIDTH+1)-1:0]     rate,
    output logic [TS_W-1:0]                issue_stamp
);
    localparam int RID_W  = $clog2(REGS);
    localparam int CHUNKS = SB_DEPTH / SB_LANES;
    localparam int CH_W   = $clog2(CHUNKS);
    localparam int CNT_W  = $clog2(WIN + 1);
    localparam int RATE_W = $clog2(WIDTH + 1);
    localparam int STEP_W = $clog2(CNT_W);

    cpre_state_t state, nxt;

    logic [CH_W-1:0]   chunk;
    logic [STEP_W-1:0] step;
    logic [TS_W-1:0]   r_regts, acc_ts;
    logic              acc_hit;
    logic [RID_W-1:0]  r_dst;
    logic              r_dst_en, r_ld, r_st;
    logic [LAT_W-1:0]  r_lat;
    logic [ADDR_W-1:0] r_addr;
    logic [CNT_W-1:0]  dvd, quo, quo_nx, occ_next;
    logic [TS_W-1:0]   dvs, rem, rem_nx;
    logic [TS_W:0]     rem_sh;
    logic              ge;

    logic [TS_W-1:0] ts_a, ts_b, reg_max, sb_ts, dep, ts_new, oldest_next, cp_len;
    logic            sb_hit, in_calc;

    assign ready   = (state == S_IDLE);
    assign in_calc = (state == S_CALC);

    cpre_regmap #(.REGS(REGS), .TS_W(TS_W)) u_regmap (
        .clk(clk), .rst_n(rst_n), .rd_a(in_src_a), .rd_b(in_src_b),
        .rd_a_ts(ts_a), .rd_b_ts(ts_b),
        .wr_en(in_calc && r_dst_en), .wr_id(r_dst), .wr_ts(ts_new)
    );

    cpre_storebuf #(.DEPTH(SB_DEPTH), .LANES(SB_LANES), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_sbuf (
        .clk(clk), .rst_n(rst_n), .push(in_calc && r_st), .push_addr(r_addr),
        .push_ts(ts_new), .chunk(chunk), .key(r_addr), .hit(sb_hit), .hit_ts(sb_ts)
    );

    cpre_window #(.WIN(WIN), .TS_W(TS_W)) u_win (
        .clk(clk), .rst_n(rst_n), .push(in_calc), .push_ts(ts_new),
        .occ_next(occ_next), .oldest_next(oldest_next)
    );

    assign reg_max = (ts_a > ts_b) ? ts_a : ts_b;
    assign dep     = (r_ld && acc_hit && (acc_ts > r_regts)) ? acc_ts : r_regts;
    assign ts_new  = dep + TS_W'(r_lat);
    assign cp_len  = (ts_new > oldest_next) ? ts_new - oldest_next : TS_W'(1);

    // One restoring-division step: quotient bit per cycle.
    assign rem_sh = {rem, dvd[CNT_W-1]};
    assign ge     = (rem_sh >= {1'b0, dvs});
    assign rem_nx = ge ? TS_W'(rem_sh - {1'b0, dvs}) : rem_sh[TS_W-1:0];
    assign quo_nx = {quo[CNT_W-2:0], ge};

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (in_valid) nxt = S_SCAN;
            S_SCAN: if (chunk == CH_W'(CHUNKS - 1)) nxt = S_CALC;
            S_CALC: nxt = S_DIV;
            S_DIV:  if (step == STEP_W'(CNT_W - 1)) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk <= '0;  step <= '0;  r_regts <= '0;  acc_ts <= '0;  acc_hit <= 1'b0;
            r_dst <= '0;  r_dst_en <= 1'b0;  r_ld <= 1'b0;  r_st <= 1'b0;
            r_lat <= '0;  r_addr <= '0;  dvd <= '0;  dvs <= '0;  rem <= '0;  quo <= '0;
            rate_valid <= 1'b0;  rate <= '0;  issue_stamp <= '0;
        end else begin
            rate_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (in_valid) begin
                    r_regts  <= reg_max;
                    r_dst    <= in_dst;
                    r_dst_en <= in_dst_en;
                    r_lat    <= in_lat;
                    r_addr   <= in_addr;
                    r_ld     <= in_is_load;
                    r_st     <= in_is_store;
                    chunk    <= '0;
                    acc_hit  <= 1'b0;
                    acc_ts   <= '0;
                end
                S_SCAN: begin
                    chunk <= chunk + 1'b1;
                    if (sb_hit) begin
                        acc_hit <= 1'b1;
                        acc_ts  <= sb_ts;
                    end
                end
                S_CALC: begin
                    issue_stamp <= ts_new;
                    dvd  <= occ_next;
                    dvs  <= cp_len;
                    rem  <= '0;
                    quo  <= '0;
                    step <= '0;
                end
                S_DIV: begin
                    dvd  <= dvd << 1;
                    rem  <= rem_nx;
                    quo  <= quo_nx;
                    step <= step + 1'b1;
                    if (step == STEP_W'(CNT_W - 1)) begin
                        rate_valid <= 1'b1;
                        rate <= (quo_nx > CNT_W'(WIDTH)) ? RATE_W'(WIDTH) : quo_nx[RATE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpath_rate_est_chk.sv
module cpath_rate_est_chk #(
    parameter int WIDTH = 4,
    parameter int LAT   = 17
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       ready,
    input logic                       rate_valid,
    input logic [$clog2(WIDTH+1)-1:0] rate
);
    logic [15:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n)                                   since <= '0;
        else if (in_valid && ready)                   since <= 16'd1;
        else if (since != '0 && since != 16'hFFFF)    since <= since + 16'd1;
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> (since == 16'(LAT + 1)));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> !ready);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !rate_valid);

    // R8
    rate_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> (32'(rate) <= WIDTH));

    // R10
    idle_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> ready);
endmodule

bind cpath_rate_est cpath_rate_est_chk #(
    .WIDTH(WIDTH),
    .LAT((SB_DEPTH / SB_LANES) + 1 + $clog2(WIN + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ready(ready),
    .rate_valid(rate_valid), .rate(rate)
);

// File: tb/cpath_rate_est_test.sv
module cpath_rate_est_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_src_a = '0, in_src_b = '0, in_dst = '0, in_lat = '0;
    logic        in_dst_en = 1'b0, in_is_load = 1'b0, in_is_store = 1'b0;
    logic [15:0] in_addr = '0;
    logic        ready, rate_valid;
    logic [2:0]  rate;
    logic [15:0] issue_stamp;

    int checks = 0;
    int errors = 0;

    int m_reg [16];
    int st_addr [0:1023];
    int st_ts   [0:1023];
    int n_st = 0;
    int hist [0:1023];
    int n_h = 0;

    always #2 clk = ~clk;

    cpath_rate_est uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst), .in_dst_en(in_dst_en), .in_lat(in_lat),
        .in_addr(in_addr), .in_is_load(in_is_load), .in_is_store(in_is_store),
        .ready(ready), .rate_valid(rate_valid), .rate(rate), .issue_stamp(issue_stamp)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int sa, input int sb, input int dst, input int den,
                          input int lat, input int addr, input int ld, input int st,
                          input string stag, input bit inject);
        int dep, ts, n, oldest, cp, rexp, k;
        string rtag;
        dep = (m_reg[sa] > m_reg[sb]) ? m_reg[sa] : m_reg[sb];
        if (ld != 0) begin
            for (int j = n_st - 1; j >= 0 && j >= n_st - 32; j--) begin
                if (st_addr[j] == addr) begin
                    if (st_ts[j] > dep) dep = st_ts[j];
                    break;
                end
            end
        end
        ts = dep + lat;
        if (den != 0) m_reg[dst] = ts;
        if (st != 0) begin st_addr[n_st] = addr; st_ts[n_st] = ts; n_st++; end
        hist[n_h] = ts; n_h++;
        n      = (n_h > 128) ? 128 : n_h;
        oldest = hist[n_h - n];
        cp     = (ts > oldest) ? ts - oldest : 1;
        rexp   = n / cp;
        if (rexp > 4) rexp = 4;
        rtag   = (n_h > 128) ? "R6 R8 window full" : (cp == 1 ? "R7 R8" : "R8");

        @(negedge clk);
        in_src_a = 4'(sa); in_src_b = 4'(sb); in_dst = 4'(dst); in_dst_en = den[0];
        in_lat = 4'(lat); in_addr = 16'(addr); in_is_load = ld[0]; in_is_store = st[0];
        in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        k = 0;
        while (k < 40) begin
            @(posedge clk); #1;
            k++;
            if (inject && k == 3) begin
                in_valid = 1'b1; in_src_a = 4'd0; in_src_b = 4'd0; in_dst = 4'd7;
                in_dst_en = 1'b1; in_lat = 4'd15; in_addr = 16'h0033;
                in_is_store = 1'b1; in_is_load = 1'b0;
            end
            if (inject && k == 4) in_valid = 1'b0;
            if (k == 1) check("R9 ready low while busy", int'(ready), 0);
            if (rate_valid) break;
        end
        check("R9 result latency", k, 17);
        check(stag, int'(issue_stamp), ts);
        check(rtag, int'(rate), rexp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(ready), 1);
        check("R1 no strobe after reset", int'(rate_valid), 0);
        check("R1 rate after reset", int'(rate), 0);
        check("R1 stamp after reset", int'(issue_stamp), 0);

        run_op(0, 0, 1, 1, 5, 0, 0, 0, "R1 empty table stamp", 1'b0);
        run_op(1, 0, 2, 1, 3, 0, 0, 0, "R2 register dependency", 1'b0);
        run_op(0, 0, 3, 1, 1, 0, 0, 0, "R7 stamp below oldest", 1'b0);
        run_op(2, 2, 1, 0, 15, 0, 0, 0, "R2 no write", 1'b0);
        run_op(1, 0, 4, 1, 2, 0, 0, 0, "R3 disabled write kept old time", 1'b0);
        run_op(2, 0, 0, 0, 4, 16'h40, 0, 1, "R2 store stamp", 1'b0);
        run_op(0, 0, 5, 1, 2, 16'h40, 1, 0, "R4 load matches store", 1'b0);
        run_op(0, 0, 5, 1, 2, 16'h41, 1, 0, "R4 load no match", 1'b0);
        run_op(0, 0, 5, 1, 2, 16'h40, 0, 0, "R4 non-load ignores store", 1'b0);

        run_op(2, 0, 0, 0, 9, 16'h80, 0, 1, "R2 store to test eviction", 1'b0);
        for (int i = 0; i < 31; i++) run_op(0, 0, 0, 0, 1, 16'h90 + i, 0, 1, "R2 filler store", 1'b0);
        run_op(0, 0, 6, 1, 1, 16'h80, 1, 0, "R5 store 31 back still matches", 1'b0);
        run_op(0, 0, 0, 0, 1, 16'hC0, 0, 1, "R2 filler store", 1'b0);
        run_op(0, 0, 6, 1, 1, 16'h80, 1, 0, "R5 store 32 back evicted", 1'b0);

        run_op(4, 0, 8, 1, 3, 0, 0, 0, "R2 op with busy pulse", 1'b1);
        run_op(7, 0, 9, 1, 1, 0, 0, 0, "R10 busy record left register", 1'b0);
        run_op(0, 0, 9, 1, 1, 16'h33, 1, 0, "R10 busy record left no store", 1'b0);

        for (int i = 0; i < 300; i++) begin
            r = int'($urandom_range(2, 0));
            run_op(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
                   int'($urandom_range(15, 0)), int'($urandom_range(1, 0)),
                   int'($urandom_range(15, 1)), int'($urandom_range(7, 0)),
                   (r == 1) ? 1 : 0, (r == 2) ? 1 : 0, "R2 R4 random stamp", 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule